// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions in program order from issue until they retire, while their results may arrive in any order. Issue logic claims an entry and gets back a tag. The entry records the kind of operation (register op, store or branch) and the destination register. Execution units later present that tag together with a result value, a side address, and flags for a mispredicted branch or a fault. A retire stage then looks only at the oldest entry. Register file and store-side state change only at that point.

While an entry has completed but not yet retired, issue logic can read its value by tag, so waiting operations take the operand from the buffer. A mispredicted branch or a faulting instruction at the oldest slot is never retired. Instead the whole buffer is discarded and a one-cycle flush pulse carries the redirect address that the instruction wrote back.

Control is a two-state machine. In `ST_RUN` the buffer allocates and retires. The transition RUN→RECOVER is taken when the oldest entry has completed with a fault, or is a branch with the mispredict flag. In `ST_RECOVER` the flush output is high for one cycle and allocation is held off. The transition RECOVER→RUN is unconditional on the next clock.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `alloc_tag_o` is 0, and `retire_o`, `reg_we_o`, `st_valid_o`, `flush_o` and `rd_ready_o` are 0.
- R2: An accepted allocation returns the tag of the next free slot. Successive allocations get successive tags modulo DEPTH, starting from 0 after reset or a flush.
- R3: After DEPTH allocations with no retirement, `alloc_ready_o` is 0 and a further request is not accepted.
- R4: Only the oldest entry retires, in allocation order, at most one per cycle. It retires in the cycle after the cycle in which its own write-back was presented, provided all older entries have already retired.
- R5: Retiring a register op (type code 2'b00) pulses `reg_we_o` for one cycle with its destination and result value.
- R6: Retiring a store (type code 2'b01) pulses `st_valid_o` for one cycle with the written-back address and value, and does not raise `reg_we_o`.
- R7: `rd_ready_o` is 1 and `rd_value_o` holds the result for a tag whose entry has been written back but not retired. `rd_ready_o` is 0 for an entry still waiting for its result, and for an entry already retired.
- R8: A branch (type code 2'b10) written back without the mispredict flag retires without a register write, a store or a flush.
- R9: A mispredicted branch at the oldest slot makes no write. No younger entry is ever written, even if it has completed. `flush_o` pulses one cycle, two cycles after the branch's write-back cycle, with `flush_exc_o` = 0 and `redirect_pc_o` equal to the branch's result value. The buffer is then empty.
- R10: A faulting entry at the oldest slot (any type) makes no write and causes the same flush with `flush_exc_o` = 1 and `redirect_pc_o` equal to its result value. Older entries retire normally first.
- R11: While `flush_o` is high, `alloc_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | Issue requests an entry |
| alloc_type_i | input | 2 | Operation kind: 00 register, 01 store, 10 branch |
| alloc_dest_i | input | REG_W | Destination register number |
| alloc_ready_o | output | 1 | An entry can be allocated this cycle |
| alloc_tag_o | output | log2(DEPTH) | Tag given to the allocating instruction |
| wb_valid_i | input | 1 | Result presented |
| wb_tag_i | input | log2(DEPTH) | Entry the result belongs to |
| wb_value_i | input | DATA_W | Result, store data or redirect address |
| wb_addr_i | input | DATA_W | Store address |
| wb_mispredict_i | input | 1 | Branch was mispredicted |
| wb_except_i | input | 1 | Instruction faulted |
| rd_tag_i | input | log2(DEPTH) | Entry looked up for an operand |
| rd_ready_o | output | 1 | Looked-up entry holds a result |
| rd_value_o | output | DATA_W | Looked-up result |
| retire_o | output | 1 | Oldest entry retired this cycle |
| reg_we_o | output | 1 | Register file write |
| reg_waddr_o | output | REG_W | Register written |
| reg_wdata_o | output | DATA_W | Value written |
| st_valid_o | output | 1 | Store released to memory path |
| st_addr_o | output | DATA_W | Store address |
| st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Buffer discarded, fetch must redirect |
| flush_exc_o | output | 1 | Flush cause: 1 fault, 0 mispredict |
| redirect_pc_o | output | DATA_W | Redirect address |

## Verification
On every cycle, the assertions check the following properties:
- Occupancy never exceeds the depth.
- Nothing is pushed when full or popped when empty.
- A retirement always finds a valid, completed oldest entry.
- A register write and a store never coincide.
- The flush pulse lasts one cycle, leaves the buffer empty and blocks allocation.

Only the bench scenarios can show the ordering and data facts: which register received which value, that retirement waits for the oldest result when younger ones finish first, that completed younger entries after a mispredict are never written, the exact flush cycle and redirect address, and the tag wrap-around.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        OP_REG    = 2'b00,
        OP_STORE  = 2'b01,
        OP_BRANCH = 2'b10
    } op_kind_e;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             clear_i,
    output logic [IDX_W-1:0] head_idx_o,
    output logic [IDX_W-1:0] tail_idx_o,
    output logic             full_o,
    output logic             empty_o
);

    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (clear_i) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push_i) tail_q <= tail_q + 1'b1;
            if (pop_i)  head_q <= head_q + 1'b1;
        end
    end

    assign head_idx_o = head_q[IDX_W-1:0];
    assign tail_idx_o = tail_q[IDX_W-1:0];
    assign empty_o    = (head_q == tail_q);
    assign full_o     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                        (head_q[PTR_W-1] != tail_q[PTR_W-1]);

    // R3
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_q - head_q) <= PTR_W'(DEPTH));

    // R3
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R4
    no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              alloc_we_i,
    input  logic [IDX_W-1:0]  alloc_idx_i,
    input  op_kind_e          alloc_kind_i,
    input  logic [REG_W-1:0]  alloc_dest_i,
    input  logic              wb_we_i,
    input  logic [IDX_W-1:0]  wb_idx_i,
    input  logic [DATA_W-1:0] wb_value_i,
    input  logic [DATA_W-1:0] wb_addr_i,
    input  logic              wb_mp_i,
    input  logic              wb_ex_i,
    input  logic              retire_i,
    input  logic [IDX_W-1:0]  head_idx_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              head_valid_o,
    output logic              head_done_o,
    output op_kind_e          head_kind_o,
    output logic [REG_W-1:0]  head_dest_o,
    output logic [DATA_W-1:0] head_value_o,
    output logic [DATA_W-1:0] head_addr_o,
    output logic              head_mp_o,
    output logic              head_ex_o,
    output logic              rd_done_o,
    output logic [DATA_W-1:0] rd_value_o
);

    logic              valid_a [DEPTH];
    logic              done_a  [DEPTH];
    op_kind_e          kind_a  [DEPTH];
    logic [REG_W-1:0]  dest_a  [DEPTH];
    logic [DATA_W-1:0] value_a [DEPTH];
    logic [DATA_W-1:0] addr_a  [DEPTH];
    logic              mp_a    [DEPTH];
    logic              ex_a    [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic              valid_q;
        logic              done_q;
        op_kind_e          kind_q;
        logic [REG_W-1:0]  dest_q;
        logic [DATA_W-1:0] value_q;
        logic [DATA_W-1:0] addr_q;
        logic              mp_q;
        logic              ex_q;
        logic              alloc_hit;
        logic              wb_hit;
        logic              ret_hit;

        assign alloc_hit = alloc_we_i && (alloc_idx_i == IDX_W'(i));
        assign wb_hit    = wb_we_i && (wb_idx_i == IDX_W'(i)) && valid_q;
        assign ret_hit   = retire_i && (head_idx_i == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
            end else if (clear_i) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
            end else if (alloc_hit) begin
                valid_q <= 1'b1;
                done_q  <= 1'b0;
            end else if (ret_hit) begin
                valid_q <= 1'b0;
                done_q  <= 1'b0;
            end else if (wb_hit) begin
                done_q  <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (alloc_hit) begin
                kind_q <= alloc_kind_i;
                dest_q <= alloc_dest_i;
            end
            if (wb_hit) begin
                value_q <= wb_value_i;
                addr_q  <= wb_addr_i;
                mp_q    <= wb_mp_i;
                ex_q    <= wb_ex_i;
            end
        end

        assign valid_a[i] = valid_q;
        assign done_a[i]  = done_q;
        assign kind_a[i]  = kind_q;
        assign dest_a[i]  = dest_q;
        assign value_a[i] = value_q;
        assign addr_a[i]  = addr_q;
        assign mp_a[i]    = mp_q;
        assign ex_a[i]    = ex_q;
    end

    assign head_valid_o = valid_a[head_idx_i];
    assign head_done_o  = done_a[head_idx_i];
    assign head_kind_o  = kind_a[head_idx_i];
    assign head_dest_o  = dest_a[head_idx_i];
    assign head_value_o = value_a[head_idx_i];
    assign head_addr_o  = addr_a[head_idx_i];
    assign head_mp_o    = mp_a[head_idx_i];
    assign head_ex_o    = ex_a[head_idx_i];
    assign rd_done_o    = valid_a[rd_idx_i] && done_a[rd_idx_i];
    assign rd_value_o   = value_a[rd_idx_i];

    // R4
    retire_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |-> (head_valid_o && head_done_o));

endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid_i,
    input  logic [1:0]        alloc_type_i,
    input  logic [REG_W-1:0]  alloc_dest_i,
    output logic              alloc_ready_o,
    output logic [IDX_W-1:0]  alloc_tag_o,
    input  logic              wb_valid_i,
    input  logic [IDX_W-1:0]  wb_tag_i,
    input  logic [DATA_W-1:0] wb_value_i,
    input  logic [DATA_W-1:0] wb_addr_i,
    input  logic              wb_mispredict_i,
    input  logic              wb_except_i,
    input  logic [IDX_W-1:0]  rd_tag_i,
    output logic              rd_ready_o,
    output logic [DATA_W-1:0] rd_value_o,
    output logic              retire_o,
    output logic              reg_we_o,
    output logic [REG_W-1:0]  reg_waddr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              st_valid_o,
    output logic [DATA_W-1:0] st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic              flush_o,
    output logic              flush_exc_o,
    output logic [DATA_W-1:0] redirect_pc_o
);

    rob_state_e state_q, state_d;

    logic [IDX_W-1:0]  head_idx, tail_idx;
    logic              full, empty;
    logic              head_valid, head_done, head_mp, head_ex;
    op_kind_e          head_kind;
    logic [REG_W-1:0]  head_dest;
    logic [DATA_W-1:0] head_value, head_addr;
    logic              head_ok, head_bad, retire, flush_now, alloc_fire;
    logic [DATA_W-1:0] redirect_q;
    logic              exc_q;

    rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (alloc_fire),
        .pop_i      (retire),
        .clear_i    (flush_now),
        .head_idx_o (head_idx),
        .tail_idx_o (tail_idx),
        .full_o     (full),
        .empty_o    (empty)
    );

    rob_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_ent (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (flush_now),
        .alloc_we_i   (alloc_fire),
        .alloc_idx_i  (tail_idx),
        .alloc_kind_i (op_kind_e'(alloc_type_i)),
        .alloc_dest_i (alloc_dest_i),
        .wb_we_i      (wb_valid_i),
        .wb_idx_i     (wb_tag_i),
        .wb_value_i   (wb_value_i),
        .wb_addr_i    (wb_addr_i),
        .wb_mp_i      (wb_mispredict_i),
        .wb_ex_i      (wb_except_i),
        .retire_i     (retire),
        .head_idx_i   (head_idx),
        .rd_idx_i     (rd_tag_i),
        .head_valid_o (head_valid),
        .head_done_o  (head_done),
        .head_kind_o  (head_kind),
        .head_dest_o  (head_dest),
        .head_value_o (head_value),
        .head_addr_o  (head_addr),
        .head_mp_o    (head_mp),
        .head_ex_o    (head_ex),
        .rd_done_o    (rd_ready_o),
        .rd_value_o   (rd_value_o)
    );

    // Oldest-entry decision
    assign head_ok  = head_valid && head_done;
    assign head_bad = head_ex || ((head_kind == OP_BRANCH) && head_mp);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Redirect capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_q <= '0;
            exc_q      <= 1'b0;
        end else if (flush_now) begin
            redirect_q <= head_value;
            exc_q      <= head_ex;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d       = state_q;
        retire        = 1'b0;
        flush_now     = 1'b0;
        alloc_ready_o = 1'b0;
        flush_o       = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                retire        = head_ok && !head_bad;
                flush_now     = head_ok && head_bad;
                alloc_ready_o = !full && !flush_now;
                if (flush_now) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                flush_o = 1'b1;
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign alloc_fire    = alloc_valid_i && alloc_ready_o;
    assign alloc_tag_o   = tail_idx;
    assign retire_o      = retire;
    assign reg_we_o      = retire && (head_kind == OP_REG);
    assign reg_waddr_o   = head_dest;
    assign reg_wdata_o   = head_value;
    assign st_valid_o    = retire && (head_kind == OP_STORE);
    assign st_addr_o     = head_addr;
    assign st_data_o     = head_value;
    assign flush_exc_o   = exc_q;
    assign redirect_pc_o = redirect_q;

    // R6
    reg_store_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_o && st_valid_o));

    // R9
    flush_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R9
    flush_leaves_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> empty);

    // R11
    flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !alloc_ready_o);

    // R10
    no_write_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_ok && head_ex) |-> !(reg_we_o || st_valid_o));

endmodule

// File: tb/spec_rob_test.sv
`timescale 1ns/1ps
module spec_rob_test;

    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid_i = 1'b0;
    logic [1:0]        alloc_type_i = 2'b00;
    logic [REG_W-1:0]  alloc_dest_i = '0;
    logic              alloc_ready_o;
    logic [IDX_W-1:0]  alloc_tag_o;
    logic              wb_valid_i = 1'b0;
    logic [IDX_W-1:0]  wb_tag_i = '0;
    logic [DATA_W-1:0] wb_value_i = '0;
    logic [DATA_W-1:0] wb_addr_i = '0;
    logic              wb_mispredict_i = 1'b0;
    logic              wb_except_i = 1'b0;
    logic [IDX_W-1:0]  rd_tag_i = '0;
    logic              rd_ready_o;
    logic [DATA_W-1:0] rd_value_o;
    logic              retire_o, reg_we_o, st_valid_o, flush_o, flush_exc_o;
    logic [REG_W-1:0]  reg_waddr_o;
    logic [DATA_W-1:0] reg_wdata_o, st_addr_o, st_data_o, redirect_pc_o;

    spec_rob #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) uut (.*);

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc_n = 0;

    int rw_n, st_n, fl_n, rt_n;
    int rw_addr [32];
    int rw_data [32];
    int rw_cyc  [32];
    int st_addr_l, st_data_l;
    int fl_pc, fl_exc, fl_cyc, fl_blocked;
    int last_wb_cyc;

    always @(posedge clk) cyc_n <= cyc_n + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (retire_o) rt_n++;
            if (reg_we_o) begin
                if (rw_n < 32) begin
                    rw_addr[rw_n] = int'(reg_waddr_o);
                    rw_data[rw_n] = int'(reg_wdata_o);
                    rw_cyc[rw_n]  = cyc_n;
                end
                rw_n++;
            end
            if (st_valid_o) begin
                st_addr_l = int'(st_addr_o);
                st_data_l = int'(st_data_o);
                st_n++;
            end
            if (flush_o) begin
                fl_pc      = int'(redirect_pc_o);
                fl_exc     = int'(flush_exc_o);
                fl_cyc     = cyc_n;
                fl_blocked = int'(!alloc_ready_o);
                fl_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_logs();
        rw_n = 0; st_n = 0; fl_n = 0; rt_n = 0;
    endtask

    task automatic do_alloc(input logic [1:0] kind, input int dest, output int tag);
        alloc_valid_i = 1'b1;
        alloc_type_i  = kind;
        alloc_dest_i  = REG_W'(dest);
        tag = int'(alloc_tag_o);
        chk(alloc_ready_o == 1'b1, "R2 alloc ready", longint'(alloc_ready_o), 1);
        tick();
        alloc_valid_i = 1'b0;
    endtask

    task automatic do_wb(input int tag, input int val, input int addr, input bit mp, input bit ex);
        wb_valid_i      = 1'b1;
        wb_tag_i        = IDX_W'(tag);
        wb_value_i      = DATA_W'(val);
        wb_addr_i       = DATA_W'(addr);
        wb_mispredict_i = mp;
        wb_except_i     = ex;
        last_wb_cyc     = cyc_n;
        tick();
        wb_valid_i      = 1'b0;
        wb_mispredict_i = 1'b0;
        wb_except_i     = 1'b0;
    endtask

    task automatic lookup(input int tag, output bit rdy, output int val);
        rd_tag_i = IDX_W'(tag);
        #1;
        rdy = rd_ready_o;
        val = int'(rd_value_o);
    endtask

    task automatic test_reset();
        bit rdy; int v;
        chk(alloc_ready_o == 1'b1, "R1 ready", longint'(alloc_ready_o), 1);
        chk(alloc_tag_o == '0, "R1 tag", longint'(alloc_tag_o), 0);
        chk(!(retire_o || reg_we_o || st_valid_o || flush_o), "R1 outputs idle",
            longint'({retire_o, reg_we_o, st_valid_o, flush_o}), 0);
        lookup(0, rdy, v);
        chk(rdy == 1'b0, "R1 lookup", longint'(rdy), 0);
    endtask

    task automatic test_inorder();
        int t0, t1, w0; bit rdy; int v;
        clear_logs();
        do_alloc(2'b00, 3, t0);
        do_alloc(2'b00, 4, t1);
        chk(t0 == 0 && t1 == 1, "R2 tags", longint'(t0 * 16 + t1), 1);
        lookup(t0, rdy, v);
        chk(rdy == 1'b0, "R7 pending not ready", longint'(rdy), 0);
        do_wb(t0, 32'h11, 0, 0, 0);
        w0 = last_wb_cyc;
        do_wb(t1, 32'h22, 0, 0, 0);
        repeat (3) tick();
        chk(rw_n == 2, "R5 write count", rw_n, 2);
        chk(rw_addr[0] == 3 && rw_data[0] == 32'h11, "R5 first write",
            longint'(rw_addr[0]), 3);
        chk(rw_addr[1] == 4 && rw_data[1] == 32'h22, "R5 second write",
            longint'(rw_data[1]), 32'h22);
        chk(rw_cyc[0] == w0 + 1, "R4 retire timing", rw_cyc[0], w0 + 1);
    endtask

    task automatic test_ooo();
        int a, b, c, wa; bit rdy; int v;
        clear_logs();
        do_alloc(2'b00, 5, a);
        do_alloc(2'b00, 6, b);
        do_alloc(2'b00, 7, c);
        do_wb(c, 32'h33, 0, 0, 0);
        repeat (2) tick();
        chk(rw_n == 0, "R4 youngest waits", rw_n, 0);
        lookup(c, rdy, v);
        chk(rdy == 1'b1 && v == 32'h33, "R7 completed lookup", longint'(v), 32'h33);
        do_wb(b, 32'h22, 0, 0, 0);
        repeat (2) tick();
        chk(rw_n == 0, "R4 middle waits", rw_n, 0);
        do_wb(a, 32'h44, 0, 0, 0);
        wa = last_wb_cyc;
        repeat (4) tick();
        chk(rw_n == 3, "R4 all retire", rw_n, 3);
        chk(rw_addr[0] == 5 && rw_addr[1] == 6 && rw_addr[2] == 7, "R4 order",
            longint'(rw_addr[0] * 256 + rw_addr[1] * 16 + rw_addr[2]), 32'h567);
        chk(rw_cyc[0] == wa + 1 && rw_cyc[1] == rw_cyc[0] + 1 && rw_cyc[2] == rw_cyc[1] + 1,
            "R4 one per cycle", longint'(rw_cyc[2] - wa), 3);
        lookup(c, rdy, v);
        chk(rdy == 1'b0, "R7 retired not ready", longint'(rdy), 0);
    endtask

    task automatic test_store();
        int t;
        clear_logs();
        do_alloc(2'b01, 0, t);
        do_wb(t, 32'hDA7A, 32'h1000, 0, 0);
        repeat (3) tick();
        chk(st_n == 1, "R6 store count", st_n, 1);
        chk(st_addr_l == 32'h1000 && st_data_l == 32'hDA7A, "R6 store fields",
            longint'(st_addr_l), 32'h1000);
        chk(rw_n == 0, "R6 no reg write", rw_n, 0);
    endtask

    task automatic test_branch_ok();
        int t;
        clear_logs();
        do_alloc(2'b10, 0, t);
        do_wb(t, 32'h400, 0, 0, 0);
        repeat (3) tick();
        chk(rt_n == 1, "R8 retired", rt_n, 1);
        chk(rw_n == 0 && st_n == 0 && fl_n == 0, "R8 no side effect",
            longint'(rw_n + st_n + fl_n), 0);
    endtask

    task automatic test_mispredict();
        int o, b, y1, y2, wb_b, n;
        clear_logs();
        do_alloc(2'b00, 9, o);
        do_alloc(2'b10, 0, b);
        do_alloc(2'b00, 10, y1);
        do_alloc(2'b01, 0, y2);
        do_wb(y1, 32'hAA, 0, 0, 0);
        do_wb(y2, 32'hBB, 32'h2222, 0, 0);
        do_wb(o, 32'h99, 0, 0, 0);
        do_wb(b, 32'h2000, 0, 1, 0);
        wb_b = last_wb_cyc;
        repeat (4) tick();
        chk(rw_n == 1 && rw_addr[0] == 9, "R9 only older written", rw_n, 1);
        chk(st_n == 0, "R9 younger store dropped", st_n, 0);
        chk(fl_n == 1 && fl_exc == 0, "R9 flush cause", longint'(fl_exc), 0);
        chk(fl_pc == 32'h2000, "R9 redirect", longint'(fl_pc), 32'h2000);
        chk(fl_cyc == wb_b + 2, "R9 flush timing", fl_cyc, wb_b + 2);
        chk(fl_blocked == 1, "R11 alloc blocked", fl_blocked, 1);
        do_alloc(2'b00, 11, n);
        chk(n == 0, "R9 empty after flush", n, 0);
        do_wb(n, 32'h77, 0, 0, 0);
        repeat (3) tick();
        chk(rw_n == 2 && rw_addr[1] == 11 && rw_data[1] == 32'h77, "R9 resumes",
            longint'(rw_addr[1]), 11);
    endtask

    task automatic test_exception();
        int old, e, y, n;
        clear_logs();
        do_alloc(2'b00, 14, old);
        do_alloc(2'b00, 12, e);
        do_alloc(2'b00, 13, y);
        do_wb(y, 32'h55, 0, 0, 0);
        do_wb(old, 32'h66, 0, 0, 0);
        do_wb(e, 32'h3000, 0, 0, 1);
        repeat (4) tick();
        chk(rw_n == 1 && rw_addr[0] == 14, "R10 older retires", rw_n, 1);
        chk(fl_n == 1 && fl_exc == 1, "R10 flush cause", longint'(fl_exc), 1);
        chk(fl_pc == 32'h3000, "R10 redirect", longint'(fl_pc), 32'h3000);
        do_alloc(2'b00, 1, n);
        chk(n == 0, "R10 empty after flush", n, 0);
        do_wb(n, 32'h1, 0, 0, 0);
        repeat (3) tick();
    endtask

    task automatic test_full();
        int tg [DEPTH];
        int err;
        clear_logs();
        err = 0;
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(2'b00, 16 + i, tg[i]);
            if (tg[i] != (1 + i) % DEPTH) err++;
        end
        chk(err == 0, "R2 tag sequence wraps", err, 0);
        chk(alloc_ready_o == 1'b0, "R3 full blocks", longint'(alloc_ready_o), 0);
        alloc_valid_i = 1'b1;
        tick();
        alloc_valid_i = 1'b0;
        for (int i = 0; i < DEPTH; i++) do_wb(tg[i], 100 + i, 0, 0, 0);
        repeat (4) tick();
        chk(rw_n == DEPTH, "R3 drained", rw_n, DEPTH);
        chk(rw_addr[DEPTH-1] == 16 + DEPTH - 1, "R3 last dest",
            longint'(rw_addr[DEPTH-1]), 16 + DEPTH - 1);
        chk(alloc_ready_o == 1'b1 && int'(alloc_tag_o) == 1, "R3 extra request ignored",
            longint'(alloc_tag_o), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        test_reset();
        test_inorder();
        test_ooo();
        test_store();
        test_branch_ok();
        test_mispredict();
        test_exception();
        test_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=complete");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule